// File: doc/BRIEF.md
# Cache-Block Maintenance Permission Probe

This block decides whether a clean, flush or invalidate of one cache block may go ahead. On a request it aligns the address down to the start of the block, then asks a permission-lookup port about that block for three kinds of access, one after another: load first, then store, then instruction fetch. The first kind that is allowed ends the check with a pass. If the port refuses all three, the block reports a store-class fault. The fault code is the guest variant when the request was made under virtualization.

Each lookup is a valid/response exchange. The block holds its query steady until the lookup port answers, so the port may take any number of cycles. The lookup covers the block only, never the rest of the page. The block performs no cache maintenance itself. It only reports whether the maintenance may go ahead.

Top module: `cbm_perm_probe`

## Requirements
- R1: After reset `busy`, `lk_valid`, `done`, `pass` and `fault` are 0 and `fault_code` is 0.
- R2: `lk_addr` equals the request address with its low log2(BLK_BYTES) bits cleared (BLK_BYTES defaults to 64).
- R3: The queries go out in a fixed order, with `lk_kind` encoded as 0 = load, 1 = store, 2 = fetch. The first query after a request is load, and after each refusal the next kind follows.
- R4: A query answered with `lk_allow`=1 ends the check. The block then sends no further query and reports `pass`=1, `fault`=0 and `fault_code`=0.
- R5: If all three queries are refused and `req_virt` was 0 when the request was taken, the block reports `fault`=1, `pass`=0 and `fault_code`=15.
- R6: If all three queries are refused and `req_virt` was 1 when the request was taken, the block reports `fault`=1, `pass`=0 and `fault_code`=23.
- R7: Once raised, `lk_valid` stays high with `lk_kind` and `lk_addr` unchanged until a cycle with `lk_resp_valid`=1. No check makes more than three queries.
- R8: A `req_valid` that arrives while `busy`=1 is ignored. It does not change the query address or order, and it produces no extra result.
- R9: `done` is a one-cycle pulse in the cycle after the deciding response. `pass`, `fault` and `fault_code` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a check; taken only when idle |
| req_addr | input | ADDR_W | Byte address inside the target block |
| req_virt | input | 1 | Request made under virtualization |
| busy | output | 1 | A check is in progress |
| lk_valid | output | 1 | Permission query valid |
| lk_kind | output | 2 | Queried access kind: 0 load, 1 store, 2 fetch |
| lk_addr | output | ADDR_W | Block-aligned address being queried |
| lk_resp_valid | input | 1 | Lookup port answers the current query |
| lk_allow | input | 1 | Answer: access kind permitted |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Check succeeded |
| fault | output | 1 | Check failed |
| fault_code | output | 5 | 15 store page fault, 23 store guest-page fault, 0 on pass |

## Verification
The bench targets permission sets in which only the second or only the third kind is allowed. A design that quit after the first refusal, or that probed in the wrong order, would give the wrong result there or the wrong count of queries. It runs the all-refused case with and without virtualization, so a swapped or constant fault code shows up. Lookup answers arrive after zero to three stall cycles, and addresses carry low offset bits and all-ones values. These catch a query that changes while it waits or an address left unaligned. A second request fired in mid-check catches a design that restarts or queues work while busy.

// File: rtl/cbm_pkg.sv
// Shared types for the cache-block permission probe.
// Assumes the lookup port understands the three-kind encoding below.
package cbm_pkg;
    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2
    } kind_e;

    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_NONE      = 5'd0;
    localparam logic [CODE_W-1:0] CODE_STORE_PF  = 5'd15;
    localparam logic [CODE_W-1:0] CODE_STORE_GPF = 5'd23;
endpackage

// File: rtl/cbm_align.sv
// Aligns a byte address down to the start of its cache block.
// Assumes BLK_BYTES is a power of two; a block of one byte passes the address through.
module cbm_align #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(BLK_BYTES - 1);

    generate
        if (BLK_BYTES > 1) begin : g_mask
            // Clear the offset bits inside the block.
            always_comb addr_out = addr_in & ~OFS_MASK;
        end else begin : g_pass
            // One-byte block: nothing to clear.
            always_comb addr_out = addr_in;
        end
    endgenerate
endmodule

// File: rtl/cbm_seq.sv
// Steps through load, store and fetch queries for one request.
// Assumes the lookup port answers each query exactly once via resp_valid.
module cbm_seq
    import cbm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr_al,
    input  logic              req_virt,
    input  logic              lk_resp_valid,
    input  logic              lk_allow,
    output logic              busy,
    output logic              lk_valid,
    output kind_e             lk_kind,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              virt_q,
    output logic              fin,
    output logic              fin_allow
);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(BLK_BYTES - 1);

    typedef enum logic {ST_IDLE, ST_PROBE} state_e;
    state_e state_q;

    // The check ends on an allowed answer or on the answer to the fetch query.
    always_comb begin
        fin       = (state_q == ST_PROBE) && lk_resp_valid &&
                    (lk_allow || lk_kind == KIND_FETCH);
        fin_allow = lk_allow;
        busy      = (state_q == ST_PROBE);
        lk_valid  = (state_q == ST_PROBE);
    end

    // Take a request when idle, then advance the access kind on each refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lk_kind <= KIND_LOAD;
            lk_addr <= '0;
            virt_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_PROBE;
                        lk_kind <= KIND_LOAD;
                        lk_addr <= req_addr_al;
                        virt_q  <= req_virt;
                    end
                end
                default: begin
                    if (lk_resp_valid) begin
                        if (fin) begin
                            state_q <= ST_IDLE;
                        end else if (lk_kind == KIND_LOAD) begin
                            lk_kind <= KIND_STORE;
                        end else begin
                            lk_kind <= KIND_FETCH;
                        end
                    end
                end
            endcase
        end
    end

    AST_QUERY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_resp_valid |=> lk_valid && $stable(lk_kind) && $stable(lk_addr)); // R7
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_addr & OFS_MASK) == '0); // R2
    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> lk_kind == KIND_LOAD); // R3
    AST_NEXT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_resp_valid && !lk_allow && lk_kind != KIND_FETCH
        |=> lk_valid && (lk_kind == $past(lk_kind) + 2'd1)); // R3
    AST_KIND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> lk_kind != 2'd3); // R7
    AST_ALLOW_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_resp_valid && lk_allow |=> !lk_valid); // R4
endmodule

// File: rtl/cbm_report.sv
// Registers the outcome of a check and picks the fault code.
// Assumes fin pulses for exactly one cycle per check.
module cbm_report
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin,
    input  logic              fin_allow,
    input  logic              virt_q,
    output logic              done,
    output logic              pass,
    output logic              fault,
    output logic [CODE_W-1:0] fault_code
);
    // Strobe done and latch the result; results hold between checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            pass       <= 1'b0;
            fault      <= 1'b0;
            fault_code <= CODE_NONE;
        end else begin
            done <= fin;
            if (fin) begin
                pass       <= fin_allow;
                fault      <= !fin_allow;
                fault_code <= fin_allow ? CODE_NONE
                            : (virt_q ? CODE_STORE_GPF : CODE_STORE_PF);
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pass != fault); // R4
    AST_PASS_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done && pass |-> fault_code == CODE_NONE); // R4
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> fault_code == CODE_STORE_PF || fault_code == CODE_STORE_GPF); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> done || ($stable(pass) && $stable(fault) && $stable(fault_code))); // R9
endmodule

// File: rtl/cbm_perm_probe.sv
// Top: permission check for cache-block clean, flush and invalidate.
// Assumes an external lookup port; performs no maintenance itself.
module cbm_perm_probe
    import cbm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_virt,
    output logic              busy,
    output logic              lk_valid,
    output logic [1:0]        lk_kind,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_resp_valid,
    input  logic              lk_allow,
    output logic              done,
    output logic              pass,
    output logic              fault,
    output logic [4:0]        fault_code
);
    logic [ADDR_W-1:0] addr_al;
    kind_e             kind;
    logic              virt_q;
    logic              fin;
    logic              fin_allow;
    logic [CODE_W-1:0] code;

    cbm_align #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_align (
        .addr_in  (req_addr),
        .addr_out (addr_al)
    );

    cbm_seq #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr_al   (addr_al),
        .req_virt      (req_virt),
        .lk_resp_valid (lk_resp_valid),
        .lk_allow      (lk_allow),
        .busy          (busy),
        .lk_valid      (lk_valid),
        .lk_kind       (kind),
        .lk_addr       (lk_addr),
        .virt_q        (virt_q),
        .fin           (fin),
        .fin_allow     (fin_allow)
    );

    cbm_report u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin        (fin),
        .fin_allow  (fin_allow),
        .virt_q     (virt_q),
        .done       (done),
        .pass       (pass),
        .fault      (fault),
        .fault_code (code)
    );

    // Present the enum and code on plain ports.
    always_comb begin
        lk_kind    = kind;
        fault_code = code;
    end

    AST_NO_QUERY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !lk_valid); // R8
endmodule

// File: tb/test_cbm_perm_probe.sv
`timescale 1ns/1ps
module test_cbm_perm_probe;
    localparam int ADDR_W = 32;
    localparam int BLK    = 64;

    typedef struct {
        logic        pass;
        logic        fault;
        logic [4:0]  code;
        int          probes;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_virt = 1'b0;
    logic busy, lk_valid, done, pass, fault;
    logic [1:0] lk_kind;
    logic [ADDR_W-1:0] lk_addr;
    logic [4:0] fault_code;
    logic lk_resp_valid = 1'b0;
    logic lk_allow = 1'b0;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int probe_idx = 0;
    int wait_cnt = 0;
    int lat = 0;
    logic [2:0] perm = 3'b000;
    logic [ADDR_W-1:0] cur_al = '0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    cbm_perm_probe #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK)) i_cbm_perm_probe (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_virt(req_virt), .busy(busy), .lk_valid(lk_valid), .lk_kind(lk_kind),
        .lk_addr(lk_addr), .lk_resp_valid(lk_resp_valid), .lk_allow(lk_allow),
        .done(done), .pass(pass), .fault(fault), .fault_code(fault_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Lookup responder and result monitor, both on the falling edge.
    always @(negedge clk) begin
        lk_resp_valid <= 1'b0;
        lk_allow      <= 1'b0;
        if (rst_n && lk_valid) begin
            if (wait_cnt < lat) begin
                wait_cnt <= wait_cnt + 1;
            end else begin
                wait_cnt <= 0;
                chk(lk_kind == 2'(probe_idx), "R3", "query kind", int'(lk_kind), probe_idx);
                chk(lk_addr == cur_al, "R2", "query address", int'(lk_addr), int'(cur_al));
                chk(probe_idx < 3, "R7", "query count", probe_idx + 1, 3);
                lk_resp_valid <= 1'b1;
                lk_allow      <= perm[lk_kind];
                probe_idx     <= probe_idx + 1;
            end
        end
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(pass == e.pass, "R4", "pass", int'(pass), int'(e.pass));
                chk(fault == e.fault, "R5", "fault", int'(fault), int'(e.fault));
                chk(fault_code == e.code, "R6", "fault_code", int'(fault_code), int'(e.code));
                chk(probe_idx == e.probes, "R4", "queries made", probe_idx, e.probes);
            end
            probe_idx <= 0;
            done_cnt  <= done_cnt + 1;
        end
    end

    // Driver: set up the lookup model, push the expectation, fire the request.
    task automatic run(input logic [ADDR_W-1:0] a, input logic v,
                       input logic [2:0] p, input int l, input bit poke_busy);
        exp_t e;
        int start;
        e.pass   = |p;
        e.fault  = ~|p;
        e.code   = (|p) ? 5'd0 : (v ? 5'd23 : 5'd15);
        e.probes = p[0] ? 1 : (p[1] ? 2 : 3);
        @(negedge clk);
        perm   = p;
        lat    = l;
        cur_al = a & ~ADDR_W'(BLK - 1);
        exp_q.push_back(e);
        start = done_cnt;
        req_valid = 1'b1;
        req_addr  = a;
        req_virt  = v;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = ~a;
            req_virt  = ~v;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait (done_cnt != start);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done width", int'(done), 0);
        repeat (3) @(negedge clk);
        chk(pass == e.pass && fault == e.fault && fault_code == e.code,
            "R9", "result hold", int'(fault_code), int'(e.code));
        chk(busy == 1'b0 && lk_valid == 1'b0 && done_cnt == start + 1,
            "R8", "idle after one result", done_cnt - start, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && lk_valid == 0 && done == 0, "R1", "control after reset",
            int'({busy, lk_valid, done}), 0);
        chk(pass == 0 && fault == 0 && fault_code == 0, "R1", "result after reset",
            int'({pass, fault, fault_code}), 0);
        rst_n = 1'b1;
        run(32'h0000_1234, 1'b0, 3'b001, 0, 1'b0); // R4 load allowed
        run(32'h0000_2047, 1'b0, 3'b010, 1, 1'b0); // R3 store allowed
        run(32'hABCD_EF3F, 1'b1, 3'b100, 2, 1'b0); // R3 fetch allowed
        run(32'h0000_4000, 1'b0, 3'b000, 0, 1'b0); // R5 all refused
        run(32'hFFFF_FFFF, 1'b1, 3'b000, 3, 1'b0); // R6 all refused, virtualized
        run(32'h1234_5601, 1'b1, 3'b110, 3, 1'b0); // R4 store first allowed
        run(32'h0000_0040, 1'b0, 3'b111, 2, 1'b0); // R4 all allowed
        run(32'h8000_007F, 1'b0, 3'b000, 3, 1'b1); // R8 request while busy
        run(32'h0F0F_0F0F, 1'b1, 3'b011, 3, 1'b1); // R8 request while busy, pass
        run(32'h0000_0000, 1'b1, 3'b000, 1, 1'b0); // R6 base address
        chk(exp_q.size() == 0, "R9", "pending expectations", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        errors++;
        checks++;
        $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule